// File: doc/BRIEF.md
# CTB Neighbour Availability Tracker

This block answers, for each prediction unit of a coding tree block (CTB), which of its five spatial neighbours are already available: the unit below-left, the unit to the left, the unit above, the unit above-right and the unit above-left. It keeps a small availability map with one 32-bit word per row of 4x4 units. The first bit of each word, its MSB, stands for the column just left of the CTB. Word 0 is the row above the CTB, and one extra word holds the row below it.

A `ctb_start` pulse seeds the map from four CTB-level flags: left, above, above-left and above-right. The seed is clipped where the picture ends to the right of or below the CTB. Each later cycle with `pu_valid` high presents one prediction unit, with its position and size counted in 4x4 units. The five flags for that unit come back combinationally in the same cycle. On the following clock edge the unit's own area is marked as available, so later units in decode order see it as a neighbour.

The CTB size is set by `LOG2_CTB`, which ranges from 4 to 6. The map always has room for the largest size.

Top module: `ctb_nbr_avail`

## Requirements
- R1: While `rst` is high, and after it until the next `ctb_start`, the map is all zero, so every neighbour flag reads 0.
- R2: A `ctb_start` clears every unit inside the CTB and every unit in the row below it. The new map takes effect on the next clock edge.
- R3: Seeding sets the left-column unit of CTB rows 0 to K-1 from `left_ctb_avail` and clears the rest of that column. K = min(2^LOG2_CTB, `rows_left`)/4.
- R4: Seeding sets the above-left corner unit (row -1, column -1) from `topleft_ctb_avail`.
- R5: Seeding sets the unit at row -1, column N from `topright_ctb_avail`, where N = 2^LOG2_CTB/4. This holds even when the columns above are clipped.
- R6: When `top_ctb_avail` is high, seeding sets units 0 to M-1 of row -1, where M = min(2^LOG2_CTB, `cols_left`)/4. The other units of that row stay clear, except for the R4 and R5 units.
- R7: For a unit at column x, row y, with width w and height h, the flags report the map at these units: `nbr_left_below` at (row y+h, column x-1); `nbr_left` at (y, x-1); `nbr_above` at (y-1, x); `nbr_above_right` at (y-1, x+w); `nbr_above_left` at (y-1, x-1). The flags are valid in the same cycle as `pu_valid`.
- R8: A cycle with `pu_valid` high (and `ctb_start` low) marks rows y to y+h-1 and columns x to x+w-1 as available from the next clock edge. A cycle with neither input high leaves the map unchanged.
- R9: The flags returned in a `pu_valid` cycle reflect the map before that unit's own mark.
- R10: When `ctb_start` and `pu_valid` are both high in the same cycle, the seed wins and the unit's mark is dropped.
- R11: Between two `ctb_start` pulses, marks accumulate: no available unit ever becomes unavailable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctb_start | input | 1 | Seed the map for a new CTB |
| left_ctb_avail | input | 1 | CTB to the left is available |
| top_ctb_avail | input | 1 | CTB above is available |
| topleft_ctb_avail | input | 1 | CTB above-left is available |
| topright_ctb_avail | input | 1 | CTB above-right is available |
| rows_left | input | DIM_W | Luma rows from the CTB top to the picture bottom |
| cols_left | input | DIM_W | Luma columns from the CTB left edge to the picture right edge |
| pu_valid | input | 1 | Unit query and mark this cycle |
| pu_x | input | 4 | Unit column in 4x4 units |
| pu_y | input | 4 | Unit row in 4x4 units |
| pu_w | input | 5 | Unit width in 4x4 units (1..N) |
| pu_h | input | 5 | Unit height in 4x4 units (1..N) |
| nbr_left_below | output | 1 | Below-left neighbour available |
| nbr_left | output | 1 | Left neighbour available |
| nbr_above | output | 1 | Above neighbour available |
| nbr_above_right | output | 1 | Above-right neighbour available |
| nbr_above_left | output | 1 | Above-left neighbour available |

## Verification
The five flags are due in the same cycle that a unit is presented, with no register between the inputs and the outputs. A seed or a mark shows in the flags of a query one clock edge later. The bench changes inputs on the falling edge and samples the flags 1 ns later, before the next rising edge. This means each flag is compared against a reference map that holds every seed and mark up to the previous edge, but not the mark of the unit being presented. Seeding is swept over all sixteen edge-flag combinations, four clip values in each direction and every unit shape and position of a 16-sample CTB, with a fresh seed before each query. A decode-order tiling then exercises same-cycle versus next-cycle visibility.

// File: rtl/ctb_avail_pkg.sv
package ctb_avail_pkg;

    localparam int WORD_W       = 32;
    localparam int MAX_LOG2_CTB = 6;
    localparam int UNIT_LOG2    = 2;
    localparam int MAX_UNITS    = 1 << (MAX_LOG2_CTB - UNIT_LOG2);
    localparam int NUM_ROWS     = MAX_UNITS + 2;
    localparam int POS_W        = $clog2(MAX_UNITS);
    localparam int SIZE_W       = POS_W + 1;
    localparam int EDGE_BIT     = WORD_W - 1;
    localparam int ROW_IDX_W    = $clog2(NUM_ROWS);
    localparam int BIT_IDX_W    = $clog2(WORD_W);

    typedef logic [WORD_W-1:0]                 row_word_t;
    typedef logic [2*WORD_W-1:0]               wide_word_t;
    typedef logic [NUM_ROWS-1:0][WORD_W-1:0]   avail_map_t;

    typedef struct packed {
        logic left;
        logic top;
        logic top_left;
        logic top_right;
    } ctb_edges_t;

    typedef struct packed {
        logic [POS_W-1:0]  x;
        logic [POS_W-1:0]  y;
        logic [SIZE_W-1:0] w;
        logic [SIZE_W-1:0] h;
    } pu_geom_t;

    typedef struct packed {
        logic left_below;
        logic left;
        logic above;
        logic above_right;
        logic above_left;
    } nbr_flags_t;

    // Run of len ones whose highest bit sits at msb; empty if it does not fit.
    function automatic row_word_t ones_run(input int msb, input int len);
        wide_word_t run;
        int         lsb;
        lsb = msb + 1 - len;
        if (len <= 0 || lsb < 0 || msb >= WORD_W) begin
            return '0;
        end
        run = (wide_word_t'(1) << len) - wide_word_t'(1);
        run = run << lsb;
        return run[WORD_W-1:0];
    endfunction

    // Number of whole 4x4 units inside the CTB, clipped by the picture edge.
    function automatic int units_in(input int remaining, input int ctb_size);
        int span;
        span = (remaining < ctb_size) ? remaining : ctb_size;
        return span >> UNIT_LOG2;
    endfunction

    // Safe single-bit read of the map; out-of-range positions read as 0.
    function automatic logic bit_at(input avail_map_t m, input int row, input int col_bit);
        if (row < 0 || row >= NUM_ROWS || col_bit < 0 || col_bit >= WORD_W) begin
            return 1'b0;
        end
        return m[row[ROW_IDX_W-1:0]][col_bit[BIT_IDX_W-1:0]];
    endfunction

endpackage

// File: rtl/avail_seed.sv
module avail_seed
    import ctb_avail_pkg::*;
#(
    parameter int LOG2_CTB = 6,
    parameter int DIM_W    = 16
) (
    input  ctb_edges_t       edges,
    input  logic [DIM_W-1:0] rows_left,
    input  logic [DIM_W-1:0] cols_left,
    output avail_map_t       seed
);
    localparam int CTB_SIZE = 1 << LOG2_CTB;
    localparam int UNITS    = CTB_SIZE >> UNIT_LOG2;
    localparam int TR_BIT   = EDGE_BIT - (1 + UNITS);

    int        rows_u;
    int        cols_u;
    row_word_t top_word;

    assign rows_u = units_in(int'(rows_left), CTB_SIZE);
    assign cols_u = units_in(int'(cols_left), CTB_SIZE);

    always_comb begin
        top_word           = '0;
        top_word[EDGE_BIT] = edges.top_left;
        top_word[TR_BIT]   = edges.top_right;
        if (edges.top) begin
            top_word = top_word | ones_run(EDGE_BIT - 1, cols_u);
        end
    end

    for (genvar k = 0; k < NUM_ROWS; k++) begin : g_row
        if (k == 0) begin : g_above
            assign seed[k] = top_word;
        end else if (k <= UNITS) begin : g_body
            assign seed[k] = {edges.left && (rows_u >= k), {(WORD_W-1){1'b0}}};
        end else begin : g_spare
            assign seed[k] = '0;
        end
    end

endmodule

// File: rtl/avail_footprint.sv
module avail_footprint
    import ctb_avail_pkg::*;
(
    input  pu_geom_t   geom,
    output avail_map_t marks
);
    row_word_t run;
    int        first_row;
    int        last_row;

    assign run       = ones_run(EDGE_BIT - 1 - int'(geom.x), int'(geom.w));
    assign first_row = 1 + int'(geom.y);
    assign last_row  = int'(geom.y) + int'(geom.h);

    for (genvar k = 0; k < NUM_ROWS; k++) begin : g_row
        assign marks[k] = (k >= first_row && k <= last_row) ? run : '0;
    end

endmodule

// File: rtl/avail_probe.sv
module avail_probe
    import ctb_avail_pkg::*;
(
    input  avail_map_t map,
    input  pu_geom_t   geom,
    output nbr_flags_t flags
);
    int px;
    int py;
    int pw;
    int ph;

    assign px = int'(geom.x);
    assign py = int'(geom.y);
    assign pw = int'(geom.w);
    assign ph = int'(geom.h);

    always_comb begin
        flags.left_below  = bit_at(map, 1 + py + ph, EDGE_BIT - px);
        flags.left        = bit_at(map, 1 + py,      EDGE_BIT - px);
        flags.above       = bit_at(map, py,          EDGE_BIT - 1 - px);
        flags.above_right = bit_at(map, py,          EDGE_BIT - 1 - px - pw);
        flags.above_left  = bit_at(map, py,          EDGE_BIT - px);
    end

endmodule

// File: rtl/ctb_nbr_avail.sv
module ctb_nbr_avail
    import ctb_avail_pkg::*;
#(
    parameter int LOG2_CTB = 6,
    parameter int DIM_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctb_start,
    input  logic              left_ctb_avail,
    input  logic              top_ctb_avail,
    input  logic              topleft_ctb_avail,
    input  logic              topright_ctb_avail,
    input  logic [DIM_W-1:0]  rows_left,
    input  logic [DIM_W-1:0]  cols_left,
    input  logic              pu_valid,
    input  logic [POS_W-1:0]  pu_x,
    input  logic [POS_W-1:0]  pu_y,
    input  logic [SIZE_W-1:0] pu_w,
    input  logic [SIZE_W-1:0] pu_h,
    output logic              nbr_left_below,
    output logic              nbr_left,
    output logic              nbr_above,
    output logic              nbr_above_right,
    output logic              nbr_above_left
);
    localparam int UNITS  = (1 << LOG2_CTB) >> UNIT_LOG2;
    localparam int TR_BIT = EDGE_BIT - (1 + UNITS);

    ctb_edges_t edges;
    pu_geom_t   geom;
    nbr_flags_t flags;
    avail_map_t map_q;
    avail_map_t seed_map;
    avail_map_t mark_map;

    assign edges.left      = left_ctb_avail;
    assign edges.top       = top_ctb_avail;
    assign edges.top_left  = topleft_ctb_avail;
    assign edges.top_right = topright_ctb_avail;

    assign geom.x = pu_x;
    assign geom.y = pu_y;
    assign geom.w = pu_w;
    assign geom.h = pu_h;

    avail_seed #(
        .LOG2_CTB (LOG2_CTB),
        .DIM_W    (DIM_W)
    ) u_seed (
        .edges     (edges),
        .rows_left (rows_left),
        .cols_left (cols_left),
        .seed      (seed_map)
    );

    avail_footprint u_footprint (
        .geom  (geom),
        .marks (mark_map)
    );

    avail_probe u_probe (
        .map   (map_q),
        .geom  (geom),
        .flags (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (ctb_start) begin
            map_q <= seed_map;
        end else if (pu_valid) begin
            map_q <= map_q | mark_map;
        end
    end

    assign nbr_left_below  = flags.left_below;
    assign nbr_left        = flags.left;
    assign nbr_above       = flags.above;
    assign nbr_above_right = flags.above_right;
    assign nbr_above_left  = flags.above_left;

    AST_START_CLEARS_BODY: assert property (@(posedge clk) disable iff (rst)
        ctb_start |=> (map_q[1][EDGE_BIT-1:0] == '0 && map_q[NUM_ROWS-1] == '0)); // R2

    AST_SEED_CORNER: assert property (@(posedge clk) disable iff (rst)
        ctb_start |=> (map_q[0][EDGE_BIT] == $past(topleft_ctb_avail))); // R4

    AST_SEED_TOPRIGHT: assert property (@(posedge clk) disable iff (rst)
        ctb_start |=> (map_q[0][TR_BIT] == $past(topright_ctb_avail))); // R5

    for (genvar k = 0; k < NUM_ROWS; k++) begin : g_chk
        AST_MAP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
            !ctb_start |=> ((map_q[k] & $past(map_q[k])) == $past(map_q[k]))); // R11

        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!ctb_start && !pu_valid) |=> $stable(map_q[k])); // R8
    end

endmodule

// File: tb/tb_ctb_nbr_avail.sv
module tb_ctb_nbr_avail;
    import ctb_avail_pkg::*;

    localparam int LOG2 = 4;
    localparam int CTB  = 1 << LOG2;
    localparam int N    = CTB / 4;
    localparam int DW   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctb_start = 1'b0;
    logic              l_in = 1'b0, t_in = 1'b0, tl_in = 1'b0, tr_in = 1'b0;
    logic [DW-1:0]     rows_left = '0, cols_left = '0;
    logic              pu_valid = 1'b0;
    logic [POS_W-1:0]  pu_x = '0, pu_y = '0;
    logic [SIZE_W-1:0] pu_w = 5'd1, pu_h = 5'd1;
    logic              o_lb, o_l, o_t, o_tr, o_tl;

    int checks = 0;
    int fails  = 0;

    bit g [0:N+1][0:N+1];

    always #2 clk = ~clk;

    ctb_nbr_avail #(.LOG2_CTB(LOG2), .DIM_W(DW)) dut (
        .clk(clk), .rst(rst), .ctb_start(ctb_start),
        .left_ctb_avail(l_in), .top_ctb_avail(t_in),
        .topleft_ctb_avail(tl_in), .topright_ctb_avail(tr_in),
        .rows_left(rows_left), .cols_left(cols_left),
        .pu_valid(pu_valid), .pu_x(pu_x), .pu_y(pu_y), .pu_w(pu_w), .pu_h(pu_h),
        .nbr_left_below(o_lb), .nbr_left(o_l), .nbr_above(o_t),
        .nbr_above_right(o_tr), .nbr_above_left(o_tl)
    );

    function automatic int clip_units(input int rem);
        return ((rem < CTB) ? rem : CTB) / 4;
    endfunction

    task automatic model_clear();
        for (int r = 0; r <= N + 1; r++)
            for (int c = 0; c <= N + 1; c++) g[r][c] = 1'b0;
    endtask

    // grid index = unit coordinate + 1 (row -1 / column -1 at index 0)
    task automatic model_seed(input bit l, input bit t, input bit tl, input bit tr,
                              input int rows, input int cols);
        model_clear();
        g[0][0]   = tl;
        g[0][N+1] = tr;
        for (int c = 0; c < clip_units(cols); c++) g[0][c+1] = t;
        for (int r = 0; r < clip_units(rows); r++) g[r+1][0] = l;
    endtask

    task automatic model_mark(input int x, input int y, input int w, input int h);
        for (int r = y; r < y + h; r++)
            for (int c = x; c < x + w; c++) g[r+1][c+1] = 1'b1;
    endtask

    function automatic logic [4:0] expect_flags(input int x, input int y, input int w, input int h);
        return {g[y+h+1][x], g[y+1][x], g[y][x+1], g[y][x+w+1], g[y][x]};
    endfunction

    task automatic check_now(input string req, input int x, input int y, input int w, input int h);
        logic [4:0] act, exp;
        act = {o_lb, o_l, o_t, o_tr, o_tl};
        exp = expect_flags(x, y, w, h);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pu=(%0d,%0d %0dx%0d) actual=%b expected=%b", req, x, y, w, h, act, exp);
        end
    endtask

    task automatic seed(input bit l, input bit t, input bit tl, input bit tr,
                        input int rows, input int cols);
        @(negedge clk);
        ctb_start = 1'b1; pu_valid = 1'b0;
        l_in = l; t_in = t; tl_in = tl; tr_in = tr;
        rows_left = DW'(rows); cols_left = DW'(cols);
        model_seed(l, t, tl, tr, rows, cols);
    endtask

    task automatic query(input string req, input int x, input int y, input int w, input int h);
        @(negedge clk);
        ctb_start = 1'b0; pu_valid = 1'b1;
        pu_x = POS_W'(x); pu_y = POS_W'(y); pu_w = SIZE_W'(w); pu_h = SIZE_W'(h);
        #1;
        check_now(req, x, y, w, h);   // R9: answer reflects map before this mark
        model_mark(x, y, w, h);
    endtask

    task automatic idle();
        @(negedge clk);
        ctb_start = 1'b0; pu_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int clipv [4] = '{300, 12, 7, 4};
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state, queried while reset is held and just after release
        pu_valid = 1'b1; pu_x = '0; pu_y = '0; pu_w = 5'd2; pu_h = 5'd2;
        #1; check_now("R1", 0, 0, 2, 2);
        @(negedge clk); rst = 1'b0; pu_valid = 1'b0;
        query("R1", 1, 1, 1, 1);
        query("R1", 3, 0, 1, 2);
        idle();

        // R3 R4 R5 R6 R7: seeding sweep, fresh seed before every query
        for (int e = 0; e < 16; e++)
            for (int ri = 0; ri < 4; ri++)
                for (int ci = 0; ci < 4; ci++)
                    for (int y = 0; y < N; y++)
                        for (int h = 1; y + h <= N; h++)
                            for (int x = 0; x < N; x++)
                                for (int w = 1; x + w <= N; w++) begin
                                    if ((x + y + w + h) % 3 == 0 || (e % 5 == 0)) begin
                                        seed(e[0], e[1], e[2], e[3], clipv[ri], clipv[ci]);
                                        query("R3 R4 R5 R6 R7", x, y, w, h);
                                    end
                                end

        // R8 R9: decode-order tiling, each unit sees earlier marks only
        seed(1, 1, 1, 1, 300, 300);
        query("R8 R9", 0, 0, 2, 2);
        query("R8 R9", 2, 0, 2, 1);
        query("R8 R9", 2, 1, 2, 1);
        query("R8 R9", 0, 2, 1, 2);
        query("R8 R9", 1, 2, 1, 2);
        query("R8 R9", 2, 2, 2, 2);
        idle();
        idle();
        // R11: full CTB stays marked; repeated queries see persistent state
        for (int y = 0; y < N; y++)
            for (int x = 0; x < N; x++) query("R11", x, y, 1, 1);

        // R2: a new seed with all edges off clears the marked body
        seed(0, 0, 0, 0, 300, 300);
        query("R2", 1, 1, 1, 1);
        seed(0, 0, 0, 0, 300, 300);
        query("R2", 2, 3, 2, 1);
        seed(0, 0, 0, 0, 300, 300);
        query("R2", 0, 0, 4, 4);

        // R10: seed and unit in the same cycle, mark must be dropped
        @(negedge clk);
        ctb_start = 1'b1; pu_valid = 1'b1;
        l_in = 1'b1; t_in = 1'b0; tl_in = 1'b0; tr_in = 1'b0;
        rows_left = DW'(300); cols_left = DW'(300);
        pu_x = '0; pu_y = '0; pu_w = 5'd1; pu_h = 5'd1;
        model_seed(1, 0, 0, 0, 300, 300);
        query("R10", 1, 0, 1, 1);
        query("R10", 0, 1, 1, 1);

        // R1: reset in mid-CTB clears everything
        query("R1", 2, 2, 2, 2);
        @(negedge clk);
        rst = 1'b1; pu_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        query("R1", 3, 3, 1, 1);
        query("R1", 1, 0, 1, 1);
        idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule